// File: doc/BRIEF.md
# Core Power-Domain Bring-Up Sequencer

This block powers up the power domain of one of two secondary processor cores and then lets that core leave reset. A single start pulse, together with a core index, launches a fixed series of register accesses on a simple request/response port. The sequencer reads the shared control register first. If the selected core is already running, it stops there. Otherwise it reads the core's power-control register once and keeps that value as a working image. It then walks through logic power-on, logic power-good, domain unclamp, memory power-down removal, memory power-on, memory power-good and memory unclamp. Every step that waits on hardware re-reads the register until its status field reports success. The final access writes the saved control value back with the core's reset-release bit set.

The block allows only one access in flight at a time. A response flagged as an error ends the run immediately. A poll that does not see its status within a software-given number of reads ends the run with a timeout. While a run is in progress, further start pulses are dropped.

Top module: `core_pwrup_seq`

## Requirements
- R1: The first access reads the control register at offset 0x30. If bit (13 + core index) of that value is 1, the run ends with `already_on_o` set, and no further access is made.
- R2: The last access of a successful run writes the control register with the value read at the start, plus bit (13 + core index) set. All other bits are preserved.
- R3: The per-core power register is at offset 0x34 + 4 × core index. It is read exactly once before the first power write, and every write to it is built from the working image.
- R4: Logic power-on sets bits 21:20 and then polls until bits 29:28 read 2'b11. Logic power-good then sets bits 17:16 and polls until bits 25:24 read 2'b11. Each poll read replaces the working image.
- R5: After logic power-good is seen, bit 15 (domain clamp) is cleared in one write. Bits 11:8 (memory power-down) are then cleared in a further write. Neither write is followed by a poll.
- R6: Memory power-on sets bit 1 and polls until bit 5 reads 1. Memory power-good then sets bit 0 and polls until bit 4 reads 1. Bit 2 (memory clamp) is then cleared before the reset-release write.
- R7: A response with the error flag set ends the run at once with `acc_err_o` set, and no further access is issued.
- R8: Each poll makes at most max(limit, 1) reads, where limit is `poll_limit_i` sampled at start. If the status is still not seen, the run ends with `timeout_o` set.
- R9: A start pulse that arrives while `busy_o` is high is ignored.
- R10: `req_valid_o` and the request fields stay stable until `req_ready_i` is seen. At most one request is outstanding, and the response is expected in a later cycle than the acceptance.
- R11: After reset, `busy_o`, `done_o` and `req_valid_o` are low. `done_o` is a one-cycle pulse. The outcome flags are valid with it and hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| core_i | input | 1 | Index of the core to bring up (0 or 1) |
| poll_limit_i | input | CNT_W | Maximum reads per poll (0 acts as 1) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| already_on_o | output | 1 | Run ended because the core was already out of reset |
| acc_err_o | output | 1 | Run ended on an access error |
| timeout_o | output | 1 | Run ended on a poll timeout |
| req_valid_o | output | 1 | Register request valid |
| req_ready_i | input | 1 | Register request accepted |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_addr_o | output | ADDR_W | Register offset |
| req_wdata_o | output | 32 | Write data |
| rsp_valid_i | input | 1 | Response valid |
| rsp_rdata_i | input | 32 | Read data |
| rsp_err_i | input | 1 | Access failed |

## Verification
The bench builds the block with its defaults: an 8-bit offset and a 16-bit poll counter. It drives `poll_limit_i` per run with 0, 4, 5 and 8. Pairing these with slave status lags of 0 to 5 reads lands runs exactly on the read-count boundary and just past it, as well as on the zero-limit case. The slave model also injects an error at chosen access numbers: the first read, a mid-sequence write and the final release write. This places every abort path and every step's ordering within reach.

// File: rtl/cps_pkg.sv
package cps_pkg;

  localparam int CTRL_OFF   = 'h30;
  localparam int PWR_BASE   = 'h34;
  localparam int PWR_STRIDE = 4;
  localparam int REL_BASE   = 13;
  localparam int NUM_STEPS  = 7;
  localparam int STEP_W     = $clog2(NUM_STEPS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RDC, S_RDP, S_WR, S_POLL, S_REL
  } seq_st_t;

  typedef struct packed {
    logic [31:0] set_m;
    logic [31:0] clr_m;
    logic        poll;
    logic [31:0] poll_m;
  } step_t;

  // power steps in the order the domain must see them
  function automatic step_t step_info(input logic [STEP_W-1:0] s);
    step_t r;
    r = '0;
    case (s)
      'd0: begin r.set_m = 32'h0030_0000; r.poll = 1'b1; r.poll_m = 32'h3000_0000; end
      'd1: begin r.set_m = 32'h0003_0000; r.poll = 1'b1; r.poll_m = 32'h0300_0000; end
      'd2: r.clr_m = 32'h0000_8000;
      'd3: r.clr_m = 32'h0000_0F00;
      'd4: begin r.set_m = 32'h0000_0002; r.poll = 1'b1; r.poll_m = 32'h0000_0020; end
      'd5: begin r.set_m = 32'h0000_0001; r.poll = 1'b1; r.poll_m = 32'h0000_0010; end
      'd6: r.clr_m = 32'h0000_0004;
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cps_port.sv
module cps_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_go,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  input  logic              rsp_err,
  output logic              cmp,
  output logic [DATA_W-1:0] cmp_rdata,
  output logic              cmp_err
);

  logic waiting;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      waiting   <= 1'b0;
      cmp       <= 1'b0;
      cmp_rdata <= '0;
      cmp_err   <= 1'b0;
    end else begin
      cmp <= 1'b0;
      if (cmd_go && !req_valid && !waiting) begin
        req_valid <= 1'b1;
        req_write <= cmd_write;
        req_addr  <= cmd_addr;
        req_wdata <= cmd_wdata;
      end
      if (req_valid && req_ready) begin
        req_valid <= 1'b0;
        waiting   <= 1'b1;
      end
      if (waiting && rsp_valid) begin
        waiting   <= 1'b0;
        cmp       <= 1'b1;
        cmp_rdata <= rsp_rdata;
        cmp_err   <= rsp_err;
      end
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_wdata) && $stable(req_write)));

  // R10
  one_out_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_go |-> (!req_valid && !waiting));

endmodule

// File: rtl/cps_poll_ctr.sv
module cps_poll_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  // this read is the final one allowed for the current poll
  assign last = ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, limit};

  // R8
  poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
    inc |-> !last);

endmodule

// File: rtl/cps_seq.sv
module cps_seq
  import cps_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              core,
  input  logic [CNT_W-1:0]  limit,
  output logic [CNT_W-1:0]  lim_q,
  output logic              busy,
  output logic              done,
  output logic              already_on,
  output logic              acc_err,
  output logic              timeout,
  output logic              cmd_go,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [31:0]       cmd_wdata,
  input  logic              cmp,
  input  logic [31:0]       cmp_rdata,
  input  logic              cmp_err,
  output logic              pc_clr,
  output logic              pc_inc,
  input  logic              pc_last
);

  seq_st_t           st;
  logic              core_q;
  logic [31:0]       ctrl_q;
  logic [31:0]       img;
  logic [STEP_W-1:0] step;

  logic [ADDR_W-1:0] ctrl_addr, pwr_addr;
  logic [31:0]       rel_mask;
  step_t             cur, nxt, first;
  logic [31:0]       adv_base, adv_img;
  logic              last_step;
  logic [ADDR_W-1:0] adv_addr;
  logic [31:0]       adv_data;
  seq_st_t           adv_st;

  always_comb begin
    ctrl_addr = ADDR_W'(CTRL_OFF);
    pwr_addr  = ADDR_W'(PWR_BASE + PWR_STRIDE * int'(core_q));
    rel_mask  = 32'd1 << (REL_BASE + int'(core_q));
    cur       = step_info(step);
    nxt       = step_info(step + 1'b1);
    first     = step_info('0);
    last_step = (int'(step) == NUM_STEPS - 1);
    adv_base  = (st == S_POLL) ? cmp_rdata : img;
    adv_img   = (adv_base | nxt.set_m) & ~nxt.clr_m;
    if (last_step) begin
      adv_addr = ctrl_addr;
      adv_data = ctrl_q | rel_mask;
      adv_st   = S_REL;
    end else begin
      adv_addr = pwr_addr;
      adv_data = adv_img;
      adv_st   = S_WR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      core_q     <= 1'b0;
      lim_q      <= '0;
      ctrl_q     <= '0;
      img        <= '0;
      step       <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      already_on <= 1'b0;
      acc_err    <= 1'b0;
      timeout    <= 1'b0;
      cmd_go     <= 1'b0;
      cmd_write  <= 1'b0;
      cmd_addr   <= '0;
      cmd_wdata  <= '0;
      pc_clr     <= 1'b0;
      pc_inc     <= 1'b0;
    end else begin
      cmd_go <= 1'b0;
      done   <= 1'b0;
      pc_clr <= 1'b0;
      pc_inc <= 1'b0;
      if (st != S_IDLE && cmp && cmp_err) begin
        st      <= S_IDLE;
        busy    <= 1'b0;
        done    <= 1'b1;
        acc_err <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            core_q     <= core;
            lim_q      <= limit;
            busy       <= 1'b1;
            already_on <= 1'b0;
            acc_err    <= 1'b0;
            timeout    <= 1'b0;
            cmd_go     <= 1'b1;
            cmd_write  <= 1'b0;
            cmd_addr   <= ADDR_W'(CTRL_OFF);
            st         <= S_RDC;
          end
          S_RDC: if (cmp) begin
            ctrl_q <= cmp_rdata;
            if ((cmp_rdata & rel_mask) != 32'd0) begin
              st         <= S_IDLE;
              busy       <= 1'b0;
              done       <= 1'b1;
              already_on <= 1'b1;
            end else begin
              cmd_go    <= 1'b1;
              cmd_write <= 1'b0;
              cmd_addr  <= pwr_addr;
              st        <= S_RDP;
            end
          end
          S_RDP: if (cmp) begin
            step      <= '0;
            img       <= (cmp_rdata | first.set_m) & ~first.clr_m;
            cmd_go    <= 1'b1;
            cmd_write <= 1'b1;
            cmd_addr  <= pwr_addr;
            cmd_wdata <= (cmp_rdata | first.set_m) & ~first.clr_m;
            st        <= S_WR;
          end
          S_WR, S_POLL: if (cmp) begin
            if (st == S_WR && cur.poll) begin
              pc_clr    <= 1'b1;
              cmd_go    <= 1'b1;
              cmd_write <= 1'b0;
              cmd_addr  <= pwr_addr;
              st        <= S_POLL;
            end else if (st == S_POLL && (cmp_rdata & cur.poll_m) != cur.poll_m) begin
              img <= cmp_rdata;
              if (pc_last) begin
                st      <= S_IDLE;
                busy    <= 1'b0;
                done    <= 1'b1;
                timeout <= 1'b1;
              end else begin
                pc_inc    <= 1'b1;
                cmd_go    <= 1'b1;
                cmd_write <= 1'b0;
                cmd_addr  <= pwr_addr;
              end
            end else begin
              img       <= last_step ? adv_base : adv_img;
              step      <= last_step ? step : step + 1'b1;
              cmd_go    <= 1'b1;
              cmd_write <= 1'b1;
              cmd_addr  <= adv_addr;
              cmd_wdata <= adv_data;
              st        <= adv_st;
            end
          end
          S_REL: if (cmp) begin
            st   <= S_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R1
  early_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_RDC && cmp && !cmp_err && cmp_rdata[REL_BASE + int'(core_q)])
      |=> (done && already_on && !cmd_go));

  // R6
  rel_after_unclamp_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_write && cmd_addr == ADDR_W'(CTRL_OFF))
      |-> (cmd_wdata[REL_BASE + int'(core_q)] && !img[2]));

  // R7
  err_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cmp && cmp_err) |=> (done && acc_err && !cmd_go && !busy));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(core_q) && $stable(lim_q)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy ##1 !done));

endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              core_i,
  input  logic [CNT_W-1:0]  poll_limit_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              already_on_o,
  output logic              acc_err_o,
  output logic              timeout_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_write_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [31:0]       req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic [31:0]       rsp_rdata_i,
  input  logic              rsp_err_i
);

  logic              cmd_go, cmd_write;
  logic [ADDR_W-1:0] cmd_addr;
  logic [31:0]       cmd_wdata;
  logic              cmp, cmp_err;
  logic [31:0]       cmp_rdata;
  logic              pc_clr, pc_inc, pc_last;
  logic [CNT_W-1:0]  lim_q;

  cps_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start_i), .core(core_i), .limit(poll_limit_i),
    .lim_q(lim_q), .busy(busy_o), .done(done_o), .already_on(already_on_o),
    .acc_err(acc_err_o), .timeout(timeout_o),
    .cmd_go(cmd_go), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmp(cmp), .cmp_rdata(cmp_rdata), .cmp_err(cmp_err),
    .pc_clr(pc_clr), .pc_inc(pc_inc), .pc_last(pc_last)
  );

  cps_port #(.ADDR_W(ADDR_W), .DATA_W(32)) u_port (
    .clk(clk), .rst(rst),
    .cmd_go(cmd_go), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .req_valid(req_valid_o), .req_ready(req_ready_i), .req_write(req_write_o),
    .req_addr(req_addr_o), .req_wdata(req_wdata_o),
    .rsp_valid(rsp_valid_i), .rsp_rdata(rsp_rdata_i), .rsp_err(rsp_err_i),
    .cmp(cmp), .cmp_rdata(cmp_rdata), .cmp_err(cmp_err)
  );

  cps_poll_ctr #(.CNT_W(CNT_W)) u_pctr (
    .clk(clk), .rst(rst), .clr(pc_clr), .inc(pc_inc), .limit(lim_q), .last(pc_last)
  );

endmodule

// File: tb/sim_core_pwrup_seq.sv
module sim_core_pwrup_seq;

  localparam logic [31:0] INIT_PWR = 32'h0000_8F04;
  localparam logic [31:0] DONE_PWR = 32'h0033_0003;
  localparam logic [31:0] CMASK    = ~32'hFF00_0030;

  typedef struct packed {
    logic        core;
    logic [31:0] ctrl;
    int          lag;
    int          err_at;
    logic [15:0] lim;
    logic [1:0]  exp;   // 0 ok, 1 already on, 2 access error, 3 timeout
    int          wr;
    int          acc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0000_0000, 0,  0, 16'd8, 2'd0, 8, 14},
    '{1'b1, 32'h0000_2000, 3,  0, 16'd8, 2'd0, 8, 26},
    '{1'b0, 32'h0000_2000, 0,  0, 16'd8, 2'd1, 0, 1},
    '{1'b1, 32'h0000_4005, 0,  0, 16'd8, 2'd1, 0, 1},
    '{1'b0, 32'h0000_0000, 5,  0, 16'd4, 2'd3, 1, 7},
    '{1'b1, 32'h0000_0000, 4,  0, 16'd5, 2'd0, 8, 30},
    '{1'b0, 32'h0000_0000, 4,  0, 16'd4, 2'd3, 1, 7},
    '{1'b1, 32'h0000_0000, 0,  1, 16'd8, 2'd2, 0, 1},
    '{1'b0, 32'h0000_0000, 0,  5, 16'd8, 2'd2, 1, 5},
    '{1'b1, 32'h0000_0000, 0, 14, 16'd8, 2'd2, 7, 14},
    '{1'b0, 32'h8001_0000, 2,  0, 16'd0, 2'd3, 1, 4},
    '{1'b1, 32'h0000_1234, 0,  0, 16'd0, 2'd0, 8, 14}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        core_i = 1'b0;
  logic [15:0] poll_limit_i = '0;
  logic        busy_o, done_o, already_on_o, acc_err_o, timeout_o;
  logic        req_valid_o, req_ready_i, req_write_o;
  logic [7:0]  req_addr_o;
  logic [31:0] req_wdata_o;
  logic        rsp_valid_i, rsp_err_i;
  logic [31:0] rsp_rdata_i;

  always #2.5 clk = ~clk;

  core_pwrup_seq u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .core_i(core_i), .poll_limit_i(poll_limit_i),
    .busy_o(busy_o), .done_o(done_o), .already_on_o(already_on_o),
    .acc_err_o(acc_err_o), .timeout_o(timeout_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_write_o(req_write_o),
    .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
    .rsp_valid_i(rsp_valid_i), .rsp_rdata_i(rsp_rdata_i), .rsp_err_i(rsp_err_i)
  );

  int total = 0, bad = 0;
  logic [31:0] m_ctrl;
  logic [31:0] m_pwr [2];
  int m_lag [2];
  bit on_seen [2], good_seen [2], mon_seen [2], mok_seen [2];
  int lag_cfg = 0, err_at = 0, rdy_dly = 0, acc_no = 0, wr_cnt = 0, viol = 0, done_cnt = 0;
  logic        c_write;
  logic [7:0]  c_addr;
  logic [31:0] c_wdata;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] status_of(input logic [31:0] v);
    logic [31:0] s;
    s = '0;
    s[29:28] = v[21:20];
    s[25:24] = v[17:16];
    s[5]     = v[1];
    s[4]     = v[0];
    return s;
  endfunction

  task automatic serve();
    int i;
    logic [31:0] o, n;
    acc_no++;
    rsp_rdata_i = '0;
    if (acc_no == err_at) begin
      rsp_err_i = 1'b1;
      return;
    end
    if (c_write) begin
      if (c_addr == 8'h30) begin
        for (int k = 0; k < 2; k++)
          if (c_wdata[13+k] && !m_ctrl[13+k] && m_pwr[k][2]) viol++;
        m_ctrl = c_wdata;
        wr_cnt++;
      end else if (c_addr == 8'h34 || c_addr == 8'h38) begin
        i = (c_addr == 8'h38) ? 1 : 0;
        o = m_pwr[i];
        n = c_wdata & CMASK;
        if (n[17:16] != 0 && o[17:16] == 0 && !on_seen[i]) viol++;
        if (!n[15] && o[15] && !good_seen[i]) viol++;
        if (n[11:8] != o[11:8] && n[15]) viol++;
        if (n[1] && !o[1] && n[11:8] != 0) viol++;
        if (n[0] && !o[0] && !mon_seen[i]) viol++;
        if (!n[2] && o[2] && !mok_seen[i]) viol++;
        m_pwr[i] = n;
        m_lag[i] = lag_cfg;
        wr_cnt++;
      end else viol++;
    end else begin
      if (c_addr == 8'h30) rsp_rdata_i = m_ctrl;
      else if (c_addr == 8'h34 || c_addr == 8'h38) begin
        i = (c_addr == 8'h38) ? 1 : 0;
        if (m_lag[i] > 0) begin
          m_lag[i]--;
          rsp_rdata_i = m_pwr[i];
        end else rsp_rdata_i = m_pwr[i] | status_of(m_pwr[i]);
        if (rsp_rdata_i[29:28] == 2'b11) on_seen[i] = 1;
        if (rsp_rdata_i[25:24] == 2'b11) good_seen[i] = 1;
        if (rsp_rdata_i[5]) mon_seen[i] = 1;
        if (rsp_rdata_i[4]) mok_seen[i] = 1;
      end else viol++;
    end
  endtask

  // register slave model
  initial begin
    int dly;
    dly = 0;
    req_ready_i = 1'b0; rsp_valid_i = 1'b0; rsp_err_i = 1'b0; rsp_rdata_i = '0;
    forever begin
      @(negedge clk);
      rsp_valid_i = 1'b0;
      rsp_err_i   = 1'b0;
      if (req_ready_i) begin
        req_ready_i = 1'b0;
        dly = 0;
        serve();
        rsp_valid_i = 1'b1;
      end else if (req_valid_o && !rst) begin
        if (dly >= rdy_dly) begin
          req_ready_i = 1'b1;
          c_write = req_write_o;
          c_addr  = req_addr_o;
          c_wdata = req_wdata_o;
        end else dly++;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (done_o) done_cnt++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic setup(input logic [31:0] ctrl, input int lag, input int err);
    m_ctrl = ctrl;
    m_pwr[0] = INIT_PWR; m_pwr[1] = INIT_PWR;
    m_lag[0] = 0; m_lag[1] = 0;
    for (int k = 0; k < 2; k++) begin
      on_seen[k] = 0; good_seen[k] = 0; mon_seen[k] = 0; mok_seen[k] = 0;
    end
    lag_cfg = lag; err_at = err; acc_no = 0; wr_cnt = 0; viol = 0;
  endtask

  task automatic run(input logic core, input logic [15:0] lim);
    int n;
    @(negedge clk);
    start_i = 1'b1; core_i = core; poll_limit_i = lim;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!done_o) begin
      bad++; total++;
      $display("FAIL run watchdog: actual=no done expected=done");
    end
  endtask

  initial begin
    int d0;
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11", "busy after reset", 32'(busy_o), 32'd0);
    check("R11", "done after reset", 32'(done_o), 32'd0);
    check("R11", "req_valid after reset", 32'(req_valid_o), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      setup(VEC[v].ctrl, VEC[v].lag, VEC[v].err_at);
      run(VEC[v].core, VEC[v].lim);
      // R1 R7 R8 outcome flags {timeout, acc_err, already_on}
      check(VEC[v].exp == 1 ? "R1" : VEC[v].exp == 2 ? "R7" : VEC[v].exp == 3 ? "R8" : "R2",
            $sformatf("v%0d outcome", v),
            {29'd0, timeout_o, acc_err_o, already_on_o},
            VEC[v].exp == 0 ? 32'd0 : 32'd1 << (VEC[v].exp - 1));
      // R3 R4 access count (one image read, poll reads)
      check("R3", $sformatf("v%0d access count", v), 32'(acc_no), 32'(VEC[v].acc));
      check("R4", $sformatf("v%0d write count", v), 32'(wr_cnt), 32'(VEC[v].wr));
      // R5 R6 ordering seen by the slave
      check("R5", $sformatf("v%0d order violations", v), 32'(viol), 32'd0);
      if (VEC[v].exp == 0) begin
        check("R2", $sformatf("v%0d ctrl final", v), m_ctrl,
              VEC[v].ctrl | (32'd1 << (13 + int'(VEC[v].core))));
        check("R6", $sformatf("v%0d power final", v), m_pwr[VEC[v].core], DONE_PWR);
        check("R3", $sformatf("v%0d other core untouched", v), m_pwr[!VEC[v].core], INIT_PWR);
      end
      if (VEC[v].exp == 1) begin
        check("R1", $sformatf("v%0d ctrl unchanged", v), m_ctrl, VEC[v].ctrl);
        check("R1", $sformatf("v%0d power unchanged", v), m_pwr[VEC[v].core], INIT_PWR);
      end
      @(negedge clk);
      // R11 done is a single pulse, flags held
      check("R11", $sformatf("v%0d done dropped", v), 32'(done_o), 32'd0);
      check("R11", $sformatf("v%0d flags held", v),
            {29'd0, timeout_o, acc_err_o, already_on_o},
            VEC[v].exp == 0 ? 32'd0 : 32'd1 << (VEC[v].exp - 1));
    end

    // R10 slow ready
    rdy_dly = 3;
    setup(32'h0, 1, 0);
    run(1'b0, 16'd8);
    check("R10", "slow ready ctrl", m_ctrl, 32'h0000_2000);
    check("R10", "slow ready power", m_pwr[0], DONE_PWR);
    check("R10", "slow ready accesses", 32'(acc_no), 32'd18);
    rdy_dly = 0;

    // R9 start while busy
    setup(32'h0, 3, 0);
    d0 = done_cnt;
    @(negedge clk);
    start_i = 1'b1; core_i = 1'b0; poll_limit_i = 16'd8;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    start_i = 1'b1; core_i = 1'b1; poll_limit_i = 16'd1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (400) @(negedge clk);
    check("R9", "done pulses", 32'(done_cnt - d0), 32'd1);
    check("R9", "second core untouched", m_pwr[1], INIT_PWR);
    check("R9", "ctrl only core0", m_ctrl, 32'h0000_2000);
    check("R9", "first run completed", m_pwr[0], DONE_PWR);
    check("R9", "no timeout from dropped limit", 32'(timeout_o), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule